// File: doc/BRIEF.md
# Reference-Compare Interval Timer

This block is a 16-bit up-counting timer driven through a small synchronous register port. A control word enables it, picks a clock divisor and decides what happens when the count meets a programmed compare value. The divisor is an 8-bit field plus one, and can be multiplied by 16 when the slow clock source is chosen. Each divided tick advances the counter by one. On a tick where the counter equals the compare value, a sticky match flag is set. In wrap mode the counter also falls back to zero on that tick.

Software reads the live count, can overwrite it, and clears the match flag by writing ones to it. The interrupt line is the match flag gated by an enable bit in the control word. The capture value and the output and edge-select control bits are only stored and read back; they drive no logic. Any write to the control word or to the compare value restarts the divider and the counter. Turning the timer off through the control word also clears the compare value.

Top module: `gp_ref_timer`

## Requirements
- R1: After reset every readable register returns 0, the counter reads 0 and `irq_o` is low.
- R2: While control bit 0 is 1, the counter advances by one once every D clock cycles. D is (control[15:8] + 1), multiplied by 16 when control[2:1] equals 2'b10.
- R3: When control bit 3 is 1, a tick that finds the counter equal to the compare value sets the counter to 0. When control bit 3 is 0, that tick sets the counter to count+1, wrapping from 0xFFFF to 0.
- R4: A tick that finds the counter equal to the compare value sets status bit 1. The bit stays set until software clears it.
- R5: `irq_o` is high exactly when control bit 4 is 1 and status bit 1 is 1.
- R6: A write to the status offset clears each status bit written as 1 and leaves bits written as 0 unchanged. If a match occurs in the same cycle, the set wins.
- R7: While control bit 0 is 0, the divider and counter stay at 0 and no match occurs. Writes to the count offset are ignored.
- R8: Any write to the control or compare offset zeroes the divider and the counter on that clock edge.
- R9: A control write that changes bit 0 from 1 to 0 clears the compare register. The control register takes the written value.
- R10: While enabled, a write to the count offset loads the counter with the written value and does not reset the divider phase.
- R11: The byte offsets are control 0x00, compare 0x04, capture 0x08, count 0x0C and status 0x11 (flags in bits 1:0). Reads return the stored value combinationally. Any other offset reads 0. Capture and control bits 7:5 are stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_o | output | 1 | Match interrupt |

## Verification
A wrong divider phase shows at the count offset within one divisor period, because the count steps one cycle early or late. A bad compare or wrap decision shows on the next tick, either as a count past the compare value or as a status flag and `irq_o` edge at the wrong cycle. The bench reads the live count every idle cycle and checks `irq_o` on every clock, so any such error appears within one tick of its cause. Restart, load and disable effects show at the port on the cycle right after the write edge.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CAPT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h11;

  localparam int CB_RUN   = 0;
  localparam int CB_WRAP  = 3;
  localparam int CB_IRQEN = 4;
  localparam logic [1:0] SRC_SLOW = 2'b10;

  typedef struct packed {
    logic ctrl;
    logic cmp;
    logic capt;
    logic cnt;
    logic stat;
  } gpt_wsel_t;
endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              match_set,
  input  logic [DATA_W-1:0] cnt_val,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic [1:0]        stat_q,
  output gpt_wsel_t         wsel,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ctrl_d, cmp_d, capt_d, capt_q;
  logic [1:0]        stat_d;
  logic              turn_off;

  always_comb begin
    wsel      = '0;
    wsel.ctrl = sel && wr && (addr == OFS_CTRL);
    wsel.cmp  = sel && wr && (addr == OFS_CMP);
    wsel.capt = sel && wr && (addr == OFS_CAPT);
    wsel.cnt  = sel && wr && (addr == OFS_CNT);
    wsel.stat = sel && wr && (addr == OFS_STAT);
  end

  assign turn_off = wsel.ctrl && ctrl_q[CB_RUN] && !wdata[CB_RUN];

  always_comb begin
    ctrl_d = ctrl_q;
    cmp_d  = cmp_q;
    capt_d = capt_q;
    stat_d = stat_q;
    if (wsel.ctrl) ctrl_d = wdata;
    if (turn_off) cmp_d = '0;
    else if (wsel.cmp) cmp_d = wdata;
    if (wsel.capt) capt_d = wdata;
    if (wsel.stat) stat_d = stat_q & ~wdata[1:0];
    if (match_set) stat_d[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      capt_q <= '0;
      stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmp_q  <= cmp_d;
      capt_q <= capt_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: rdata = ctrl_q;
      OFS_CMP:  rdata = cmp_q;
      OFS_CAPT: rdata = capt_q;
      OFS_CNT:  rdata = cnt_val;
      OFS_STAT: rdata = {{(DATA_W-2){1'b0}}, stat_q};
      default:  rdata = '0;
    endcase
  end

  // R4: a match leaves the flag set
  a_r4_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    match_set |=> stat_q[1]);
  // R6: a write-one clear without a coincident match drops the flag
  a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel.stat && wdata[1] && !match_set) |=> !stat_q[1]);
  // R9: switching off wipes the compare value
  a_r9_cmp_wiped: assert property (@(posedge clk) disable iff (!rst_n)
    turn_off |=> (cmp_q == '0));
endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PS_W      = 8,
  parameter int SLOW_LOG2 = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            restart,
  input  logic            slow,
  input  logic [PS_W-1:0] ps_val,
  output logic            tick
);
  localparam int DIV_W = PS_W + SLOW_LOG2;

  logic [DIV_W-1:0] div_m1;
  logic [DIV_W-1:0] pre_q, pre_d;

  generate
    if (SLOW_LOG2 > 0) begin : g_slow
      assign div_m1 = slow ? {ps_val, {SLOW_LOG2{1'b1}}}
                           : {{SLOW_LOG2{1'b0}}, ps_val};
    end else begin : g_noslow
      assign div_m1 = ps_val;
    end
  endgenerate

  assign tick = en && (pre_q == div_m1);

  always_comb begin
    pre_d = pre_q + 1'b1;
    if (!en || restart || tick) pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R2: the phase never passes the selected divisor
  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= div_m1);
  // R7: no phase advance while stopped
  a_r7_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pre_q == '0));
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             wrap_mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_set
);
  logic [CNT_W-1:0] cnt_d;
  logic             hit;

  assign hit       = (cnt_q == cmp_val);
  assign match_set = tick && hit && !restart;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !en)   cnt_d = '0;
    else if (load)        cnt_d = load_val;
    else if (tick)        cnt_d = (hit && wrap_mode) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: a stopped timer holds its count at zero
  a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
  // R3: wrap mode returns to zero on the matching tick
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && hit && wrap_mode && !restart && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/gp_ref_timer.sv
module gp_ref_timer
  import gpt_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PS_W      = 8,
  parameter int SLOW_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int PS_LSB = 8;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [DATA_W-1:0] ctrl, cmp, cnt;
  logic [1:0]        stat;
  gpt_wsel_t         wsel;
  logic              tick, match_set, restart, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign run     = ctrl[CB_RUN];
  assign restart = wsel.ctrl || wsel.cmp;

  gpt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .sel(bus_sel), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .match_set(match_set),
    .cnt_val(cnt), .ctrl_q(ctrl), .cmp_q(cmp), .stat_q(stat),
    .wsel(wsel), .rdata(bus_rdata)
  );

  gpt_prescaler #(.PS_W(PS_W), .SLOW_LOG2(SLOW_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .en(run), .restart(restart),
    .slow(ctrl[2:1] == SRC_SLOW), .ps_val(ctrl[PS_LSB +: PS_W]),
    .tick(tick)
  );

  gpt_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .en(run), .restart(restart),
    .tick(tick), .load(wsel.cnt), .load_val(bus_wdata), .cmp_val(cmp),
    .wrap_mode(ctrl[CB_WRAP]), .cnt_q(cnt), .match_set(match_set)
  );

  assign irq_o = ctrl[CB_IRQEN] && stat[1];

  // R8: a control or compare write leaves the count at zero
  a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    restart |=> (cnt == '0));
  // R5: no interrupt without a pending match
  a_r5_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_o && !$past(match_set)) |-> $past(stat[1]));
endmodule

// File: tb/test_gp_ref_timer.sv
module test_gp_ref_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = 5'h0C;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int unsigned m_ctrl, m_cmp, m_capt, m_cnt, m_stat, m_pre;
  int unsigned en, dv, tk, wc, wm, wrf, wcap, ws, rs, ms;

  gp_ref_timer i_gp_ref_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic int unsigned m_read(input int unsigned a);
    case (a)
      5'h00: return m_ctrl;
      5'h04: return m_cmp;
      5'h08: return m_capt;
      5'h0C: return m_cnt;
      5'h11: return m_stat;
      default: return 0;
    endcase
  endfunction

  // behavioural reference model, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cmp = 0; m_capt = 0; m_cnt = 0; m_stat = 0; m_pre = 0;
    end else begin
      cycles++;
      en   = m_ctrl & 1;
      dv   = ((m_ctrl >> 8) + 1) * ((((m_ctrl >> 1) & 3) == 2) ? 16 : 1);
      tk   = (en != 0 && m_pre == dv - 1) ? 1 : 0;
      wm   = (bus_sel && bus_wr && bus_addr == 5'h00) ? 1 : 0;
      wrf  = (bus_sel && bus_wr && bus_addr == 5'h04) ? 1 : 0;
      wcap = (bus_sel && bus_wr && bus_addr == 5'h08) ? 1 : 0;
      wc   = (bus_sel && bus_wr && bus_addr == 5'h0C) ? 1 : 0;
      ws   = (bus_sel && bus_wr && bus_addr == 5'h11) ? 1 : 0;
      rs   = wm | wrf;
      ms   = (tk != 0 && m_cnt == m_cmp && rs == 0) ? 1 : 0;
      if (en == 0 || rs != 0 || tk != 0) m_pre = 0; else m_pre++;
      if (rs != 0 || en == 0) m_cnt = 0;
      else if (wc != 0) m_cnt = bus_wdata;
      else if (tk != 0) m_cnt = (ms != 0 && (m_ctrl & 8) != 0) ? 0 : ((m_cnt + 1) & 16'hFFFF);
      if (ws != 0) m_stat = m_stat & ~bus_wdata & 3;
      if (ms != 0) m_stat = m_stat | 2;
      if (wcap != 0) m_capt = bus_wdata;
      if (wm != 0) begin
        if ((m_ctrl & 1) != 0 && (bus_wdata & 1) == 0) m_cmp = 0;
        m_ctrl = bus_wdata;
      end
      if (wrf != 0) m_cmp = bus_wdata;
    end
  end

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 irq", irq_o, ((m_ctrl & 16) != 0 && (m_stat & 2) != 0) ? 1 : 0);
      if (bus_sel && !bus_wr) begin
        if (bus_addr == 5'h0C)      chk("R2 count", bus_rdata, m_read(bus_addr));
        else if (bus_addr == 5'h11) chk("R4 status", bus_rdata, m_read(bus_addr));
        else                        chk("R11 read", bus_rdata, m_read(bus_addr));
      end
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = 5'h0C; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input int unsigned exp, input string tag);
    @(posedge clk); #2;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
    bus_addr = 5'h0C;
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset values
    @(negedge clk) chk("R1 irq", irq_o, 0);
    rd_chk(5'h00, 0, "R1 ctrl");
    rd_chk(5'h04, 0, "R1 cmp");
    rd_chk(5'h0C, 0, "R1 count");
    rd_chk(5'h11, 0, "R1 status");
    // R11: storage and unmapped offsets
    wr_reg(5'h08, 16'hBEEF);
    rd_chk(5'h08, 16'hBEEF, "R11 capture");
    rd_chk(5'h02, 0, "R11 unmapped");
    rd_chk(5'h10, 0, "R11 unmapped");
    // R2: divisor 3, free running
    wr_reg(5'h04, 16'h0100);
    wr_reg(5'h00, 16'h02E1);
    @(negedge clk) chk("R8 count after ctrl write", bus_rdata, 0);
    rd_chk(5'h00, 16'h02E1, "R11 ctrl bits stored");
    idle(40);
    // R3/R4/R5: wrap mode, divisor 1, compare 5, irq enabled
    wr_reg(5'h04, 16'h0005);
    wr_reg(5'h00, 16'h0019);
    @(negedge clk) chk("R8 count after restart", bus_rdata, 0);
    idle(10);
    rd_chk(5'h11, 2, "R4 match flag");
    @(negedge clk) chk("R5 irq high", irq_o, 1);
    bus_addr = 5'h0C;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      checks++;
      if (bus_rdata > 16'd5) begin
        errors++;
        $display("FAIL R3: actual 0x%0h expected <= 0x5", bus_rdata);
      end
    end
    // R6: zero write keeps, one write clears
    wr_reg(5'h11, 16'h0000);
    rd_chk(5'h11, 2, "R6 zero keeps");
    wr_reg(5'h0C, 16'h0100);
    wr_reg(5'h11, 16'h0002);
    rd_chk(5'h11, 0, "R6 one clears");
    @(negedge clk) chk("R5 irq low", irq_o, 0);
    // R2: slow source, divisor 2*16
    wr_reg(5'h04, 16'h0003);
    wr_reg(5'h00, 16'h010D);
    idle(300);
    // R10: load while enabled with a long divisor
    wr_reg(5'h00, 16'hFF05);
    wr_reg(5'h0C, 16'h1234);
    @(negedge clk) chk("R10 load", bus_rdata, 16'h1234);
    idle(5);
    // R3: free running wrap from 0xFFFF
    wr_reg(5'h00, 16'h0001);
    wr_reg(5'h0C, 16'hFFFE);
    @(negedge clk) chk("R10 load", bus_rdata, 16'hFFFE);
    @(negedge clk) chk("R3 count", bus_rdata, 16'hFFFF);
    @(negedge clk) chk("R3 wrap", bus_rdata, 16'h0000);
    idle(10);
    // R9: switching off clears compare
    wr_reg(5'h04, 16'h00AA);
    wr_reg(5'h00, 16'h0010);
    rd_chk(5'h04, 0, "R9 cmp cleared");
    rd_chk(5'h00, 16'h0010, "R9 ctrl written");
    // R7: stopped timer ignores count writes
    wr_reg(5'h0C, 16'h0055);
    @(negedge clk) chk("R7 count held", bus_rdata, 0);
    idle(20);
    rd_chk(5'h0C, 0, "R7 still zero");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule